// File: doc/BRIEF.md
# Interprocessor Mailbox with Channel Ownership and Acknowledge Handshake

This block is a register-mapped mailbox. A local processor uses it to hand a fixed message of eight 32-bit words to a remote processor and to learn when the remote side has taken it. The block holds a parameterised number of channels. Each channel has its own 16-word register window. A single global lock word, guarded by a key, decides whether any channel register may be written.

To send, software first unlocks the block. It then claims an idle channel by writing a one-hot owner vector into the channel's owner register and reading it back. Next it sets the destination vector, the interrupt mask and the acknowledge mode, and fills the eight data words. It launches the transfer by writing the owner vector to the launch register. While the channel is in flight, the unmasked destination bits are driven on the destination interrupt output. When the remote acknowledge input arrives, the channel moves to the acknowledged state and drives its owner vector on the acknowledge interrupt output. In self-acknowledge mode, a fixed cycle delay can also end the flight. Writing the owner vector to the clear register returns the channel to ready.

Addresses on the port are word addresses; the byte offset of a register is four times its word address. Channel c occupies words 16c to 16c+15, byte window 0x40·c. The lock word sits at word 0x280, byte 0xA00.

Top module: `mailbox_ipc`

## Requirements
- R1: After reset, every channel reads its status word (word offset 4) as 0x10, idle. Its mask (offset 5) reads 0xFFFFFFFF. Its owner, destination and data words read 0. The lock word reads 1 and both interrupt outputs are 0.
- R2: Writing 0x1ACCE551 to the lock word clears it to 0, and writing any other value sets it back to 1. While it reads 1, writes to every channel register have no effect.
- R3: A write to the owner register (offset 0) takes effect only when the channel is idle and the value has exactly one bit set. The value is then stored and the channel becomes ready. The status word shows bit 4 for idle, bit 5 for ready, bit 6 for in flight and bit 7 for acknowledged. Exactly one of these four bits is set at any time.
- R4: Writing 0 to the owner register of a ready channel clears the owner and returns the channel to idle.
- R5: The eight message words live at offsets 8 to 15 (bytes 0x20 to 0x3C). Each is written and read back independently.
- R6: A write to the launch register (offset 7) whose value equals the stored owner vector moves a ready channel to in flight. Any other value, or a launch in any other state, is ignored. While in flight, the destination interrupt output carries the channel's destination bits that are not masked.
- R7: A mask bit of 1 suppresses the matching destination interrupt bit, and a mask bit of 0 lets it through.
- R8: An in-flight channel becomes acknowledged one cycle after a cycle in which its acknowledge input is high. With status bit 0 set (self-acknowledge, set by writing 1 to offset 4), it also becomes acknowledged after ACK_DLY cycles in flight. While acknowledged, its owner vector is driven on the acknowledge interrupt output.
- R9: Writing the owner vector to the clear register (offset 6) of an acknowledged channel returns it to ready. Other values are ignored.
- R10: A write to offset 1 sets destination bits. A write to offset 2 clears the destination bits that are 1 in the written value. Offsets 1 and 3 both read the destination vector.
- R11: Reads of word addresses outside every channel window and other than the lock word return 0. Writes there change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_i | input | 1 | Register write strobe |
| addr_i | input | 10 | Word address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i, combinational |
| ack_in_i | input | NCH | Remote acknowledge, one bit per channel |
| dst_irq_o | output | 32 | OR of unmasked destination vectors of in-flight channels |
| ack_irq_o | output | 32 | OR of owner vectors of acknowledged channels |

## Verification
The assertions assume the remote acknowledge input matters only while a channel is in flight, and that the register port carries at most one write per cycle. The stimulus holds wr_i and addr_i stable from one falling edge to the next and pulses each acknowledge input for a single cycle. Some of those pulses are deliberately sent to channels that are not in flight, to show that they are ignored. The lock guard is exercised in both directions: writes are attempted both while locked and while unlocked.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  localparam int DW        = 32;
  localparam int MSG_WORDS = 8;
  localparam logic [31:0] UNLOCK_KEY = 32'h1ACC_E551;
  localparam logic [9:0]  LOCK_WADDR = 10'h280;

  // word offsets inside a channel window
  localparam logic [3:0] OFF_OWNER  = 4'd0;
  localparam logic [3:0] OFF_DSET   = 4'd1;
  localparam logic [3:0] OFF_DCLR   = 4'd2;
  localparam logic [3:0] OFF_DSTAT  = 4'd3;
  localparam logic [3:0] OFF_STATUS = 4'd4;
  localparam logic [3:0] OFF_MASK   = 4'd5;
  localparam logic [3:0] OFF_ICLR   = 4'd6;
  localparam logic [3:0] OFF_LAUNCH = 4'd7;

  typedef enum logic [1:0] {
    CH_IDLE  = 2'd0,
    CH_READY = 2'd1,
    CH_FLY   = 2'd2,
    CH_ACKED = 2'd3
  } chan_state_e;

  function automatic logic single_bit(input logic [DW-1:0] v);
    return (v != '0) && ((v & (v - 1'b1)) == '0);
  endfunction

  function automatic logic [DW-1:0] status_word(input chan_state_e st,
                                                input logic self_ack);
    logic [DW-1:0] w;
    w    = '0;
    w[0] = self_ack;
    w[4] = (st == CH_IDLE);
    w[5] = (st == CH_READY);
    w[6] = (st == CH_FLY);
    w[7] = (st == CH_ACKED);
    return w;
  endfunction
endpackage

// File: rtl/mbx_lock.sv
module mbx_lock
  import mbx_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [DW-1:0] wdata_i,
  output logic          engaged_o
);
  logic engaged_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) engaged_q <= 1'b1;
    else if (we_i) engaged_q <= (wdata_i != UNLOCK_KEY);
  end

  assign engaged_o = engaged_q;
endmodule

// File: rtl/mbx_decode.sv
module mbx_decode
  import mbx_pkg::*;
#(
  parameter int NCH = 4
) (
  input  logic           wr_i,
  input  logic [9:0]     addr_i,
  input  logic           engaged_i,
  output logic           lock_hit_o,
  output logic           lock_we_o,
  output logic [NCH-1:0] chan_sel_o,
  output logic [NCH-1:0] chan_we_o,
  output logic [3:0]     off_o
);
  logic [5:0] idx;

  assign idx        = addr_i[9:4];
  assign off_o      = addr_i[3:0];
  assign lock_hit_o = (addr_i == LOCK_WADDR);
  assign lock_we_o  = wr_i && lock_hit_o;

  for (genvar c = 0; c < NCH; c++) begin : g_sel
    assign chan_sel_o[c] = !lock_hit_o && (idx == 6'(c));
    assign chan_we_o[c]  = chan_sel_o[c] && wr_i && !engaged_i;
  end
endmodule

// File: rtl/mbx_chan.sv
module mbx_chan
  import mbx_pkg::*;
#(
  parameter int ACK_DLY = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [3:0]    off_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          ack_in_i,
  output logic [DW-1:0] rdata_o,
  output logic [DW-1:0] dst_vec_o,
  output logic [DW-1:0] ack_vec_o,
  output logic          idle_o,
  output logic          ready_o,
  output logic          fly_o,
  output logic          acked_o
);
  localparam int CW = $clog2(ACK_DLY + 1);

  chan_state_e   st_q;
  logic [DW-1:0] owner_q, dst_q, mask_q;
  logic          self_ack_q;
  logic [CW-1:0] cnt_q;
  logic [DW-1:0] data_q [MSG_WORDS];

  logic launch_ok, clear_ok, claim_ok, release_ok, timeout_hit;

  assign claim_ok    = we_i && off_i == OFF_OWNER && st_q == CH_IDLE && single_bit(wdata_i);
  assign release_ok  = we_i && off_i == OFF_OWNER && st_q == CH_READY && wdata_i == '0;
  assign launch_ok   = we_i && off_i == OFF_LAUNCH && st_q == CH_READY && wdata_i == owner_q;
  assign clear_ok    = we_i && off_i == OFF_ICLR && st_q == CH_ACKED && wdata_i == owner_q;
  assign timeout_hit = self_ack_q && (cnt_q == CW'(ACK_DLY - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= CH_IDLE;
      owner_q    <= '0;
      dst_q      <= '0;
      mask_q     <= '1;
      self_ack_q <= 1'b0;
      cnt_q      <= '0;
      for (int i = 0; i < MSG_WORDS; i++) data_q[i] <= '0;
    end else begin
      if (st_q == CH_FLY) begin
        if (ack_in_i || timeout_hit) st_q <= CH_ACKED;
        else                         cnt_q <= cnt_q + 1'b1;
      end
      if (claim_ok) begin
        owner_q <= wdata_i;
        st_q    <= CH_READY;
      end
      if (release_ok) begin
        owner_q <= '0;
        st_q    <= CH_IDLE;
      end
      if (launch_ok) begin
        st_q  <= CH_FLY;
        cnt_q <= '0;
      end
      if (clear_ok) st_q <= CH_READY;
      if (we_i) begin
        unique case (off_i)
          OFF_DSET:   dst_q      <= dst_q | wdata_i;
          OFF_DCLR:   dst_q      <= dst_q & ~wdata_i;
          OFF_STATUS: self_ack_q <= wdata_i[0];
          OFF_MASK:   mask_q     <= wdata_i;
          default: if (off_i[3]) data_q[off_i[2:0]] <= wdata_i;
        endcase
      end
    end
  end

  always_comb begin
    unique case (off_i)
      OFF_OWNER:             rdata_o = owner_q;
      OFF_DSET, OFF_DSTAT:   rdata_o = dst_q;
      OFF_STATUS:            rdata_o = status_word(st_q, self_ack_q);
      OFF_MASK:              rdata_o = mask_q;
      OFF_DCLR, OFF_ICLR,
      OFF_LAUNCH:            rdata_o = '0;
      default:               rdata_o = data_q[off_i[2:0]];
    endcase
  end

  assign dst_vec_o = (st_q == CH_FLY)   ? (dst_q & ~mask_q) : '0;
  assign ack_vec_o = (st_q == CH_ACKED) ? owner_q : '0;
  assign idle_o    = (st_q == CH_IDLE);
  assign ready_o   = (st_q == CH_READY);
  assign fly_o     = (st_q == CH_FLY);
  assign acked_o   = (st_q == CH_ACKED);
endmodule

// File: rtl/mailbox_ipc.sv
module mailbox_ipc
  import mbx_pkg::*;
#(
  parameter int NCH     = 4,
  parameter int ACK_DLY = 8
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           wr_i,
  input  logic [9:0]     addr_i,
  input  logic [31:0]    wdata_i,
  output logic [31:0]    rdata_o,
  input  logic [NCH-1:0] ack_in_i,
  output logic [31:0]    dst_irq_o,
  output logic [31:0]    ack_irq_o
);
  // named internal events, observed by the bound checker
  logic           lock_engaged;
  logic           lock_hit, lock_we;
  logic [NCH-1:0] chan_sel, chan_we;
  logic [3:0]     off;
  logic [NCH-1:0] st_idle, st_ready, st_fly, st_acked;
  logic [DW-1:0]  chan_rd  [NCH];
  logic [DW-1:0]  chan_dst [NCH];
  logic [DW-1:0]  chan_ack [NCH];

  mbx_lock u_lock (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (lock_we),
    .wdata_i   (wdata_i),
    .engaged_o (lock_engaged)
  );

  mbx_decode #(.NCH(NCH)) u_dec (
    .wr_i       (wr_i),
    .addr_i     (addr_i),
    .engaged_i  (lock_engaged),
    .lock_hit_o (lock_hit),
    .lock_we_o  (lock_we),
    .chan_sel_o (chan_sel),
    .chan_we_o  (chan_we),
    .off_o      (off)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_chan
    mbx_chan #(.ACK_DLY(ACK_DLY)) u_chan (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .we_i      (chan_we[c]),
      .off_i     (off),
      .wdata_i   (wdata_i),
      .ack_in_i  (ack_in_i[c]),
      .rdata_o   (chan_rd[c]),
      .dst_vec_o (chan_dst[c]),
      .ack_vec_o (chan_ack[c]),
      .idle_o    (st_idle[c]),
      .ready_o   (st_ready[c]),
      .fly_o     (st_fly[c]),
      .acked_o   (st_acked[c])
    );
  end

  always_comb begin
    rdata_o   = lock_hit ? {31'b0, lock_engaged} : '0;
    dst_irq_o = '0;
    ack_irq_o = '0;
    for (int c = 0; c < NCH; c++) begin
      if (chan_sel[c]) rdata_o = rdata_o | chan_rd[c];
      dst_irq_o = dst_irq_o | chan_dst[c];
      ack_irq_o = ack_irq_o | chan_ack[c];
    end
  end
endmodule

// File: rtl/mbx_checker.sv
module mbx_checker #(
  parameter int NCH = 4
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic           lock_engaged,
  input logic [NCH-1:0] st_idle,
  input logic [NCH-1:0] st_ready,
  input logic [NCH-1:0] st_fly,
  input logic [NCH-1:0] st_acked,
  input logic [31:0]    dst_irq_o,
  input logic [31:0]    ack_irq_o
);
  for (genvar c = 0; c < NCH; c++) begin : g_chk
    assert_state_onehot_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $countones({st_idle[c], st_ready[c], st_fly[c], st_acked[c]}) == 1);

    assert_lock_holds_idle_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (lock_engaged && st_idle[c]) |=> st_idle[c]);

    assert_ready_entry_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(st_ready[c]) |-> $past(st_idle[c] || st_acked[c]));

    assert_launch_from_ready_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(st_fly[c]) |-> $past(st_ready[c]));

    assert_ack_from_flight_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(st_acked[c]) |-> $past(st_fly[c]));

    assert_clear_to_ready_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(st_acked[c]) |-> st_ready[c]);
  end

  assert_dst_quiet_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_fly == '0) |-> (dst_irq_o == '0));

  assert_ack_quiet_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_acked == '0) |-> (ack_irq_o == '0));
endmodule

bind mailbox_ipc mbx_checker #(.NCH(NCH)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .lock_engaged (lock_engaged),
  .st_idle      (st_idle),
  .st_ready     (st_ready),
  .st_fly       (st_fly),
  .st_acked     (st_acked),
  .dst_irq_o    (dst_irq_o),
  .ack_irq_o    (ack_irq_o)
);

// File: tb/mailbox_ipc_test.sv
module mailbox_ipc_test;
  localparam int NCH = 4;
  localparam int DLY = 8;
  localparam logic [31:0] KEY = 32'h1ACC_E551;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           wr = 1'b0;
  logic [9:0]     addr = '0;
  logic [31:0]    wdata = '0;
  logic [31:0]    rdata, dst_irq, ack_irq;
  logic [NCH-1:0] ack_in = '0;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  always #4 clk = ~clk;   // 125 MHz

  mailbox_ipc #(.NCH(NCH), .ACK_DLY(DLY)) uut (
    .clk_i(clk), .rst_ni(rst_n), .wr_i(wr), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .ack_in_i(ack_in), .dst_irq_o(dst_irq), .ack_irq_o(ack_irq)
  );

  // behavioural reference: 0 idle, 1 ready, 2 in flight, 3 acknowledged
  int          ms   [NCH];
  int          mcnt [NCH];
  logic [31:0] mown [NCH], mdst [NCH], mmask [NCH];
  bit          mauto[NCH];
  logic [31:0] mdat [NCH][8];
  bit          mlock;

  function automatic void model_reset();
    mlock = 1;
    for (int c = 0; c < NCH; c++) begin
      ms[c] = 0; mcnt[c] = 0; mown[c] = 0; mdst[c] = 0;
      mmask[c] = 32'hFFFF_FFFF; mauto[c] = 0;
      for (int i = 0; i < 8; i++) mdat[c][i] = 0;
    end
  endfunction

  function automatic logic [31:0] exp_rd(input logic [9:0] a);
    int c;
    if (a == 10'h280) return {31'b0, mlock};
    c = int'(a[9:4]);
    if (c >= NCH) return 0;
    case (int'(a[3:0]))
      0: return mown[c];
      1, 3: return mdst[c];
      4: return (32'(mauto[c])) | (32'h10 << ms[c]);
      5: return mmask[c];
      2, 6, 7: return 0;
      default: return mdat[c][a[2:0]];
    endcase
  endfunction

  function automatic string tag_of(input logic [9:0] a);
    if (a == 10'h280) return "R2";
    if (int'(a[9:4]) >= NCH) return "R11";
    case (int'(a[3:0]))
      0, 4: return "R3";
      1, 2, 3: return "R10";
      5: return "R7";
      6: return "R9";
      7: return "R6";
      default: return "R5";
    endcase
  endfunction

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h at %0t", req, got, exp, $time);
    end
  endtask

  initial model_reset();

  always @(posedge clk) begin
    int pre [NCH];
    int c;
    logic [3:0] o;
    if (!rst_n) model_reset();
    else begin
      for (int k = 0; k < NCH; k++) pre[k] = ms[k];
      if (wr) begin
        if (addr == 10'h280) mlock = (wdata != KEY);
        else if (!mlock && int'(addr[9:4]) < NCH) begin
          c = int'(addr[9:4]);
          o = addr[3:0];
          case (int'(o))
            0: if (pre[c] == 0 && $countones(wdata) == 1) begin mown[c] = wdata; ms[c] = 1; end
               else if (pre[c] == 1 && wdata == 0) begin mown[c] = 0; ms[c] = 0; end
            1: mdst[c] = mdst[c] | wdata;
            2: mdst[c] = mdst[c] & ~wdata;
            3: ;
            4: mauto[c] = wdata[0];
            5: mmask[c] = wdata;
            6: if (pre[c] == 3 && wdata == mown[c]) ms[c] = 1;
            7: if (pre[c] == 1 && wdata == mown[c]) begin ms[c] = 2; mcnt[c] = 0; end
            default: mdat[c][o[2:0]] = wdata;
          endcase
        end
      end
      for (int k = 0; k < NCH; k++)
        if (pre[k] == 2) begin
          if (ack_in[k] || (mauto[k] && mcnt[k] == DLY - 1)) ms[k] = 3;
          else mcnt[k]++;
        end
    end
    #2;
    if (rst_n && !done) begin
      logic [31:0] ed, ea;
      ed = 0; ea = 0;
      for (int k = 0; k < NCH; k++) begin
        if (ms[k] == 2) ed |= mdst[k] & ~mmask[k];
        if (ms[k] == 3) ea |= mown[k];
      end
      check("R6", dst_irq, ed);
      check("R8", ack_irq, ea);
      check(tag_of(addr), rdata, exp_rd(addr));
    end
  end

  task automatic wr_reg(input logic [9:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [9:0] a, input logic [31:0] exp);
    @(negedge clk);
    addr = a;
    #1;
    check(req, rdata, exp);
  endtask

  task automatic pulse_ack(input int c);
    @(negedge clk);
    ack_in[c] = 1'b1;
    @(negedge clk);
    ack_in[c] = 1'b0;
  endtask

  function automatic logic [9:0] ra(input int c, input int off);
    return 10'(c * 16 + off);
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    rd_chk("R1", ra(0, 4), 32'h10);
    rd_chk("R1", ra(3, 4), 32'h10);
    rd_chk("R1", ra(2, 5), 32'hFFFF_FFFF);
    rd_chk("R1", ra(1, 9), 32'h0);
    rd_chk("R1", 10'h280, 32'h1);
    check("R1", dst_irq | ack_irq, 32'h0);
    // R2 locked writes ignored
    wr_reg(ra(0, 0), 32'h4);
    rd_chk("R2", ra(0, 0), 32'h0);
    rd_chk("R2", ra(0, 4), 32'h10);
    wr_reg(10'h280, KEY);
    rd_chk("R2", 10'h280, 32'h0);
    // R3 acquire rules
    wr_reg(ra(0, 0), 32'h4);
    rd_chk("R3", ra(0, 0), 32'h4);
    rd_chk("R3", ra(0, 4), 32'h20);
    wr_reg(ra(1, 0), 32'h6);
    rd_chk("R3", ra(1, 4), 32'h10);
    wr_reg(ra(0, 0), 32'h8);
    rd_chk("R3", ra(0, 0), 32'h4);
    // R5 message words
    for (int i = 0; i < 8; i++) wr_reg(ra(0, 8 + i), 32'hA5A5_0000 + 32'(i * 3));
    for (int i = 0; i < 8; i++) rd_chk("R5", ra(0, 8 + i), 32'hA5A5_0000 + 32'(i * 3));
    // R10 destination set/clear
    wr_reg(ra(0, 1), 32'h11);
    wr_reg(ra(0, 2), 32'h01);
    rd_chk("R10", ra(0, 3), 32'h10);
    rd_chk("R10", ra(0, 1), 32'h10);
    // R7/R6 launch with self-acknowledge
    wr_reg(ra(0, 5), ~32'h10);
    wr_reg(ra(0, 4), 32'h1);
    wr_reg(ra(0, 7), 32'h8);
    rd_chk("R6", ra(0, 4), 32'h21);
    wr_reg(ra(0, 7), 32'h4);
    rd_chk("R6", ra(0, 4), 32'h41);
    check("R7", dst_irq, 32'h10);
    repeat (DLY + 2) @(negedge clk);
    rd_chk("R8", ra(0, 4), 32'h81);
    check("R8", ack_irq, 32'h4);
    wr_reg(ra(0, 6), 32'h2);
    rd_chk("R9", ra(0, 4), 32'h81);
    wr_reg(ra(0, 6), 32'h4);
    rd_chk("R9", ra(0, 4), 32'h21);
    // R8 manual mode waits for remote acknowledge; R7 mask partial
    pulse_ack(1);   // ignored: channel 1 idle
    rd_chk("R8", ra(1, 4), 32'h10);
    wr_reg(ra(1, 0), 32'h1);
    wr_reg(ra(1, 1), 32'h3);
    wr_reg(ra(1, 5), 32'hFFFF_FFFE);
    wr_reg(ra(1, 7), 32'h1);
    repeat (20) @(negedge clk);
    rd_chk("R8", ra(1, 4), 32'h40);
    check("R7", dst_irq, 32'h1);
    wr_reg(ra(1, 5), 32'h0);
    #1 check("R7", dst_irq, 32'h3);
    pulse_ack(1);
    rd_chk("R8", ra(1, 4), 32'h80);
    check("R8", ack_irq, 32'h1);
    // R6 launch in idle ignored; R4 release
    wr_reg(ra(2, 0), 32'h0);
    wr_reg(ra(2, 7), 32'h0);
    rd_chk("R6", ra(2, 4), 32'h10);
    wr_reg(ra(0, 0), 32'h0);
    rd_chk("R4", ra(0, 4), 32'h11);
    rd_chk("R4", ra(0, 0), 32'h0);
    // R11 outside windows
    wr_reg(10'h040, 32'hDEAD_BEEF);
    rd_chk("R11", 10'h040, 32'h0);
    rd_chk("R11", 10'h3FF, 32'h0);
    // R2 relock
    wr_reg(10'h280, 32'h0);
    rd_chk("R2", 10'h280, 32'h1);
    wr_reg(ra(2, 5), 32'h0);
    rd_chk("R2", ra(2, 5), 32'hFFFF_FFFF);
    repeat (2) @(negedge clk);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule